// File: doc/BRIEF.md
# Asymmetric Step-Clock Pulse Generator

This block produces the stepping clock for an output register that advances through a stored table. On each falling edge of that clock, the target fetches the next table line. The target then needs a long processing interval before the following rising edge can present that line at its output. The rising edge itself only needs to be held for a very short time. A symmetric square wave would have to stretch its high phase to match the long low phase, so it wastes about half of every period.

This generator programs the high and low phases separately, in system-clock cycles. With the parameter defaults of a 10000-cycle minimum low phase and a 1-cycle minimum high phase at 100 MHz, the shortest period is 10001 cycles. That is roughly 9999 updates per second, against about 5000 for a symmetric clock that meets the same low-time limit.

A run begins with a single-cycle start request. The block latches the step count and both phase lengths. It then raises the clock line and a table-enable line in the same cycle, which is the initial output time. It toggles the clock for the requested number of rising edges and then returns both lines low with a one-cycle completion pulse. A start request whose phase lengths fall below the target's minimums, or whose step count is zero, is refused and flagged. While a run is active, the block reports the achieved period in cycles.

Top module: `asym_step_clock`

## Requirements
- R1: While reset is active and in the first cycle after it, stepClk, tableEn, done and cfgErr are 0, and periodCycles is 0.
- R2: A start request sampled high while idle, with a valid configuration, makes stepClk and tableEn both 1 in the very next cycle.
- R3: Each high phase of stepClk lasts exactly highCount cycles, using the value latched at start.
- R4: Between high phases, stepClk stays low for exactly lowCount cycles, and a run produces exactly stepCount rising edges of stepClk.
- R5: In the cycle after the last high phase, stepClk and tableEn are 0 and done is 1 for exactly that one cycle.
- R6: A start request with lowCount below MIN_LOW, highCount below MIN_HIGH, or stepCount equal to 0 is refused: cfgErr is 1 in the next cycle and tableEn stays 0.
- R7: cfgErr holds at 1 until the next accepted start request, which clears it in the same cycle that tableEn rises.
- R8: From the first cycle of an accepted run, periodCycles equals the latched lowCount plus highCount, and it keeps that value after the run ends.
- R9: During a run, start requests and changes to stepCount, lowCount or highCount have no effect on stepClk, tableEn, done, cfgErr or periodCycles.
- R10: Phase lengths exactly equal to MIN_LOW and MIN_HIGH are accepted, and a low phase one cycle shorter than MIN_LOW is refused.

Each rule above relies on stepClk = 1 meaning the clock line is high, and tableEn = 1 meaning the enable line is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start request, sampled while idle |
| stepCount | input | STEP_W | Number of rising edges to produce |
| lowCount | input | CNT_W | Low phase length in cycles |
| highCount | input | CNT_W | High phase length in cycles |
| stepClk | output | 1 | Stepping clock line |
| tableEn | output | 1 | Table enable line, high for the whole run |
| done | output | 1 | One-cycle pulse when the run ends |
| cfgErr | output | 1 | Set when a start request is refused |
| periodCycles | output | CNT_W+1 | Achieved step period in cycles |

## Verification
Let a start request be sampled at edge k. Every output is registered, so stepClk, tableEn and periodCycles all change in the cycle that begins at edge k+1. A refusal makes cfgErr show its new value at that same edge. For N steps with period P = H + L, the clock is high in the cycles t = 1 + iP through H + iP (counting from edge k+1 as t = 1). Done and the fall of tableEn land on t = H + (N-1)P + 1. The bench computes this cycle-indexed waveform from the inputs alone. It samples every output on the falling clock edge of each cycle from t = 1 through the done cycle, so no comparison ever depends on the ordering of processes at the rising edge.

// File: rtl/asc_pkg.sv
package asc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_LOW  = 2'd2
  } ascState_t;

  // Strobes sent from the control FSM to the datapath.
  typedef struct packed {
    logic load;       // latch configuration, arm first high phase
    logic enterHigh;  // reload high length, consume one step
    logic enterLow;   // reload low length
    logic tick;       // count down the current phase
  } ascStrobes_t;

endpackage

// File: rtl/asc_datapath.sv
module asc_datapath
  import asc_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int STEP_W   = 16,
  parameter int MIN_LOW  = 10000,
  parameter int MIN_HIGH = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ascStrobes_t       stb,
  input  logic [STEP_W-1:0] stepCount,
  input  logic [CNT_W-1:0]  lowCount,
  input  logic [CNT_W-1:0]  highCount,
  output logic              cfgOk,
  output logic              phaseLast,
  output logic              lastStep,
  output logic [CNT_W:0]    periodCycles
);

  // A zero-length phase would never end, so both minimums are forced to at least one cycle.
  localparam int MinLowEff  = (MIN_LOW  < 1) ? 1 : MIN_LOW;
  localparam int MinHighEff = (MIN_HIGH < 1) ? 1 : MIN_HIGH;
  localparam logic [CNT_W-1:0] MinLowV  = CNT_W'(MinLowEff);
  localparam logic [CNT_W-1:0] MinHighV = CNT_W'(MinHighEff);

  logic [CNT_W-1:0]  lowReg;
  logic [CNT_W-1:0]  highReg;
  logic [CNT_W-1:0]  phaseCnt;
  logic [STEP_W-1:0] stepsLeft;

  assign cfgOk = (lowCount >= MinLowV) && (highCount >= MinHighV) && (stepCount != '0);
  assign phaseLast = (phaseCnt == CNT_W'(1));
  assign lastStep  = (stepsLeft == STEP_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowReg       <= '0;
      highReg      <= '0;
      phaseCnt     <= '0;
      stepsLeft    <= '0;
      periodCycles <= '0;
    end else begin
      if (stb.load) begin
        lowReg       <= lowCount;
        highReg      <= highCount;
        phaseCnt     <= highCount;
        stepsLeft    <= stepCount;
        periodCycles <= {1'b0, lowCount} + {1'b0, highCount};
      end else if (stb.enterHigh) begin
        phaseCnt  <= highReg;
        stepsLeft <= stepsLeft - STEP_W'(1);
      end else if (stb.enterLow) begin
        phaseCnt <= lowReg;
      end else if (stb.tick) begin
        phaseCnt <= phaseCnt - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/asc_control.sv
module asc_control
  import asc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        cfgOk,
  input  logic        phaseLast,
  input  logic        lastStep,
  output ascStrobes_t stb,
  output logic        stepClk,
  output logic        tableEn,
  output logic        done,
  output logic        cfgErr
);

  ascState_t state;
  ascState_t stateNext;
  logic      clkNext;
  logic      enNext;
  logic      doneNext;
  logic      errNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    clkNext   = stepClk;
    enNext    = tableEn;
    doneNext  = 1'b0;
    errNext   = cfgErr;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          if (cfgOk) begin
            stb.load  = 1'b1;
            stateNext = ST_HIGH;
            clkNext   = 1'b1;
            enNext    = 1'b1;
            errNext   = 1'b0;
          end else begin
            errNext = 1'b1;
          end
        end
      end
      ST_HIGH: begin
        if (phaseLast) begin
          clkNext = 1'b0;
          if (lastStep) begin
            stateNext = ST_IDLE;
            enNext    = 1'b0;
            doneNext  = 1'b1;
          end else begin
            stb.enterLow = 1'b1;
            stateNext    = ST_LOW;
          end
        end else begin
          stb.tick = 1'b1;
        end
      end
      ST_LOW: begin
        if (phaseLast) begin
          stb.enterHigh = 1'b1;
          stateNext     = ST_HIGH;
          clkNext       = 1'b1;
        end else begin
          stb.tick = 1'b1;
        end
      end
      default: begin
        stateNext = ST_IDLE;
        clkNext   = 1'b0;
        enNext    = 1'b0;
      end
    endcase
  end

  // Output lines are registered directly so they never glitch on state decode.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepClk <= 1'b0;
      tableEn <= 1'b0;
      done    <= 1'b0;
      cfgErr  <= 1'b0;
    end else begin
      state   <= stateNext;
      stepClk <= clkNext;
      tableEn <= enNext;
      done    <= doneNext;
      cfgErr  <= errNext;
    end
  end

endmodule

// File: rtl/asym_step_clock.sv
module asym_step_clock
  import asc_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int STEP_W   = 16,
  parameter int MIN_LOW  = 10000,
  parameter int MIN_HIGH = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [STEP_W-1:0] stepCount,
  input  logic [CNT_W-1:0]  lowCount,
  input  logic [CNT_W-1:0]  highCount,
  output logic              stepClk,
  output logic              tableEn,
  output logic              done,
  output logic              cfgErr,
  output logic [CNT_W:0]    periodCycles
);

  ascStrobes_t stb;
  logic cfgOk;
  logic phaseLast;
  logic lastStep;

  asc_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .cfgOk     (cfgOk),
    .phaseLast (phaseLast),
    .lastStep  (lastStep),
    .stb       (stb),
    .stepClk   (stepClk),
    .tableEn   (tableEn),
    .done      (done),
    .cfgErr    (cfgErr)
  );

  asc_datapath #(
    .CNT_W    (CNT_W),
    .STEP_W   (STEP_W),
    .MIN_LOW  (MIN_LOW),
    .MIN_HIGH (MIN_HIGH)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .stepCount    (stepCount),
    .lowCount     (lowCount),
    .highCount    (highCount),
    .cfgOk        (cfgOk),
    .phaseLast    (phaseLast),
    .lastStep     (lastStep),
    .periodCycles (periodCycles)
  );

endmodule

// File: rtl/asc_checker.sv
module asc_checker #(
  parameter int MIN_LOW  = 10000,
  parameter int MIN_HIGH = 1
) (
  input logic clk,
  input logic rstN,
  input logic stepClk,
  input logic tableEn,
  input logic done,
  input logic cfgErr
);

  // Run lengths of the current level of stepClk, saturating.
  int unsigned lowRun;
  int unsigned highRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowRun  <= 0;
      highRun <= 0;
    end else begin
      if (stepClk) begin
        lowRun  <= 0;
        highRun <= (highRun == 32'hFFFF_FFFF) ? highRun : highRun + 1;
      end else begin
        highRun <= 0;
        lowRun  <= (lowRun == 32'hFFFF_FFFF) ? lowRun : lowRun + 1;
      end
    end
  end

  AST_LOW_MIN: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(stepClk) && $past(tableEn)) |-> (lowRun >= MIN_LOW)); // R4

  AST_HIGH_MIN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stepClk) |-> (highRun >= MIN_HIGH)); // R3

  AST_CLK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    stepClk |-> tableEn); // R2

  AST_RISE_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tableEn) |-> (stepClk && !cfgErr)); // R2 R7

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tableEn) |-> (done && !stepClk)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R5

  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgErr) |-> !tableEn); // R6

endmodule

bind asym_step_clock asc_checker #(
  .MIN_LOW  (MIN_LOW),
  .MIN_HIGH (MIN_HIGH)
) u_asc_checker (
  .clk     (clk),
  .rstN    (rstN),
  .stepClk (stepClk),
  .tableEn (tableEn),
  .done    (done),
  .cfgErr  (cfgErr)
);

// File: tb/asym_step_clock_test.sv
module asym_step_clock_test;

  localparam int CNT_W    = 16;
  localparam int STEP_W   = 16;
  localparam int MIN_LOW  = 20;
  localparam int MIN_HIGH = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startReq = 1'b0;
  logic [STEP_W-1:0] stepCount = '0;
  logic [CNT_W-1:0]  lowCount = '0;
  logic [CNT_W-1:0]  highCount = '0;
  logic              stepClk;
  logic              tableEn;
  logic              done;
  logic              cfgErr;
  logic [CNT_W:0]    periodCycles;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  asym_step_clock #(
    .CNT_W(CNT_W), .STEP_W(STEP_W), .MIN_LOW(MIN_LOW), .MIN_HIGH(MIN_HIGH)
  ) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stepCount(stepCount),
    .lowCount(lowCount), .highCount(highCount), .stepClk(stepClk),
    .tableEn(tableEn), .done(done), .cfgErr(cfgErr), .periodCycles(periodCycles)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Accepted run: compare the whole waveform with the cycle-indexed expectation.
  task automatic runCase(input int n, input int h, input int l, input bit disturb);
    int p = h + l;
    int endT = h + (n - 1) * p;
    int badClk = 0, badEn = 0, badDone = 0, badErr = 0, badPer = 0, rises = 0;
    logic prevClk = 1'b0;
    @(negedge clk);
    stepCount = STEP_W'(n);
    highCount = CNT_W'(h);
    lowCount  = CNT_W'(l);
    startReq  = 1'b1;
    for (int t = 1; t <= endT + 1; t++) begin
      @(negedge clk);
      startReq = 1'b0;
      if (disturb && t == 2) begin
        startReq  = 1'b1;
        stepCount = STEP_W'(1);
        highCount = CNT_W'(h + 3);
        lowCount  = CNT_W'(0);
      end
      if (stepClk !== ((t <= endT) && (((t - 1) % p) < h))) badClk++;
      if (tableEn !== (t <= endT)) badEn++;
      if (done !== (t == endT + 1)) badDone++;
      if (cfgErr !== 1'b0) badErr++;
      if (periodCycles !== (CNT_W+1)'(p)) badPer++;
      if (stepClk === 1'b1 && prevClk === 1'b0) rises++;
      prevClk = stepClk;
    end
    startReq = 1'b0;
    chk(badClk == 0, "R3 R4", "stepClk mismatching cycles", badClk, 0);
    chk(badEn == 0, "R2 R5", "tableEn mismatching cycles", badEn, 0);
    chk(badDone == 0, "R5", "done mismatching cycles", badDone, 0);
    chk(rises == n, "R4", "rising edges", rises, n);
    chk(badPer == 0, "R8", "periodCycles mismatching cycles", badPer, 0);
    if (disturb) chk(badErr == 0, "R9", "cfgErr set by ignored request", badErr, 0);
    else         chk(badErr == 0, "R7", "cfgErr during accepted run", badErr, 0);
    @(negedge clk);
    chk(done == 1'b0 && tableEn == 1'b0, "R5", "done/tableEn after end", {done, tableEn}, 0);
    chk(periodCycles == (CNT_W+1)'(p), "R8", "periodCycles held after run", periodCycles, p);
  endtask

  // Refused request: flag next cycle, enable never rises.
  task automatic rejectCase(input int n, input int h, input int l, input string req);
    int enSeen = 0;
    @(negedge clk);
    stepCount = STEP_W'(n);
    highCount = CNT_W'(h);
    lowCount  = CNT_W'(l);
    startReq  = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk(cfgErr == 1'b1, req, "cfgErr after refused start", cfgErr, 1);
    for (int i = 0; i < 5; i++) begin
      if (tableEn !== 1'b0 || stepClk !== 1'b0) enSeen++;
      @(negedge clk);
    end
    chk(enSeen == 0, req, "outputs active after refusal", enSeen, 0);
    chk(cfgErr == 1'b1, "R7", "cfgErr held while idle", cfgErr, 1);
  endtask

  task automatic resetCase();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk({stepClk, tableEn, done, cfgErr} == 4'b0, "R1", "outputs in reset",
        {stepClk, tableEn, done, cfgErr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk({stepClk, tableEn, done, cfgErr} == 4'b0, "R1", "outputs after reset",
        {stepClk, tableEn, done, cfgErr}, 0);
    chk(periodCycles == '0, "R1", "periodCycles after reset", periodCycles, 0);
  endtask

  // Error then a valid start: cfgErr clears in the cycle tableEn rises.
  task automatic clearCase();
    rejectCase(2, MIN_HIGH - 1, MIN_LOW, "R6");
    @(negedge clk);
    stepCount = STEP_W'(1);
    highCount = CNT_W'(MIN_HIGH);
    lowCount  = CNT_W'(MIN_LOW);
    startReq  = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk(cfgErr == 1'b0 && tableEn == 1'b1 && stepClk == 1'b1, "R7",
        "cfgErr/tableEn/stepClk at accepted start", {cfgErr, tableEn, stepClk}, 3'b011);
    repeat (MIN_HIGH + 2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    resetCase();
    runCase(3, 4, 25, 1'b0);                  // R2 R3 R4 R5 R8 typical
    runCase(1, 7, 30, 1'b0);                  // R5 single step
    runCase(4, MIN_HIGH, MIN_LOW, 1'b0);      // R10 exact minimums accepted
    runCase(3, 5, 22, 1'b1);                  // R9 disturbed run
    rejectCase(2, 4, MIN_LOW - 1, "R10");     // R10 one below low minimum
    rejectCase(0, 4, 30, "R6");               // R6 zero steps
    clearCase();                              // R6 R7
    runCase(2, 3, 21, 1'b0);                  // R8 new period after previous run
    summary();
  end

endmodule